// File: doc/BRIEF.md
# Clock-Output Pin Function Selector

This block owns one general-purpose output pin and decides what it carries. An 8-bit control register picks one of four pin functions. The first is a clock derived from the 12 MHz reference by a power-of-two divider. The second is an active-low power-amplifier enable. The third is the serial radio data stream. The fourth is a plain level taken from a GPIO input. Selecting the GPIO function and holding its level low is how the pin is switched off.

The same register holds a crystal-stable interrupt enable. After a wake pulse, the block latches an event on the first rising edge of `crystal_stable`, but only while the enable is set. The event stays pending until software writes the enable bit to zero. When the serial-data function is selected and the serial port runs in 3-wire mode, the MISO pin carries the bit clock that goes with the data stream instead of normal port data.

The whole block runs on the reference clock. Its reset is asserted asynchronously and released synchronously inside the block.

Top module: `clkout_sel`

## Requirements
- R1: After reset the register reads 0x04 (fields: function bits 7:6, interrupt enable bit 5, frequency bits 2:0). Bits 4:3 always read 0, even when they are written with 1.
- R2: With function 00 and frequency code 0, the pin follows the reference clock: high in the high phase, low in the low phase.
- R3: With function 00 and frequency code k from 1 to 4, the pin toggles every 2^(k-1) reference cycles.
- R4: With function 00 and frequency code 5, 6 or 7, the pin stays low.
- R5: A change of frequency code restarts the divider, so the first high phase after the change lasts a full 2^(k-1) cycles.
- R6: With function 01, the pin carries the inverse of `pa_on`, registered by one reference cycle.
- R7: With function 10, the pin carries `ser_data`.
- R8: With function 11, the pin carries `gpio_level`.
- R9: `miso_out` equals `ser_clk` when function 10 is selected and `three_wire_mode` is high. Otherwise it equals `spi_miso_data`.
- R10: With the enable bit (bit 5) set, the first rising edge of `crystal_stable` after a `wake` pulse raises `xtal_irq` one cycle later. The interrupt then stays high.
- R11: No event is latched when the enable bit is clear, or when no wake pulse came before the rising edge.
- R12: A write with bit 5 equal to 0 clears a pending event, and `xtal_irq` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| pa_on | input | 1 | Power-amplifier on request, active high |
| ser_data | input | 1 | Serial radio data bit |
| ser_clk | input | 1 | Bit clock of the serial data |
| gpio_level | input | 1 | Level driven in GPIO function |
| three_wire_mode | input | 1 | Serial port is in 3-wire mode |
| spi_miso_data | input | 1 | Normal serial-port output data |
| wake | input | 1 | Wake-from-sleep pulse |
| crystal_stable | input | 1 | Crystal oscillator stable flag |
| pin_out | output | 1 | Selected clock-output pin level |
| miso_out | output | 1 | MISO pin level |
| xtal_irq | output | 1 | Pending crystal-stable interrupt |

## Verification
The bench builds the block with its default parameters: a 3-bit frequency field whose highest defined code is 4, and an 8-bit register. With these values, all five divided rates and the three undefined codes can be reached by plain register writes. Each divided rate is checked by measuring the lengths of high and low runs at the pin. A code switch part-way through a phase shows whether the restart leaves a runt pulse. The interrupt arm, capture and clear sequence is driven through its enabled, disabled and no-wake cases.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    FN_DIVCLK = 2'b00,
    FN_PA_N   = 2'b01,
    FN_SERIAL = 2'b10,
    FN_GPIO   = 2'b11
  } pin_fn_e;

  localparam int FN_MSB     = 7;
  localparam int FN_LSB     = 6;
  localparam int IRQ_EN_BIT = 5;
endpackage

// File: rtl/clkout_ctrl_reg.sv
module clkout_ctrl_reg #(
  parameter int DATA_W   = 8,
  parameter int FREQ_W   = 3,
  parameter int FREQ_RST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wake,
  input  logic                crystal_stable,
  output logic [DATA_W-1:0]   rd_data,
  output clkout_pkg::pin_fn_e fn,
  output logic [FREQ_W-1:0]   freq,
  output logic                irq
);
  import clkout_pkg::*;

  pin_fn_e           fn_q, fn_d;
  logic              en_q, en_d;
  logic [FREQ_W-1:0] freq_q, freq_d;
  logic              armed_q, armed_d;
  logic              evt_q, evt_d;
  logic              cs_q;
  logic              cs_rise;

  assign cs_rise = crystal_stable & ~cs_q;

  always_comb begin
    fn_d    = fn_q;
    en_d    = en_q;
    freq_d  = freq_q;
    armed_d = armed_q;
    evt_d   = evt_q;
    if (wr_en) begin
      fn_d   = pin_fn_e'(wr_data[FN_MSB:FN_LSB]);
      en_d   = wr_data[IRQ_EN_BIT];
      freq_d = wr_data[FREQ_W-1:0];
    end
    if (wake) begin
      armed_d = 1'b1;
    end else if (armed_q && cs_rise) begin
      armed_d = 1'b0;
      if (en_q) evt_d = 1'b1;
    end
    if (wr_en && !wr_data[IRQ_EN_BIT]) evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q    <= FN_DIVCLK;
      en_q    <= 1'b0;
      freq_q  <= FREQ_W'(FREQ_RST);
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      fn_q    <= fn_d;
      en_q    <= en_d;
      freq_q  <= freq_d;
      armed_q <= armed_d;
      evt_q   <= evt_d;
      cs_q    <= crystal_stable;
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[FN_MSB:FN_LSB]       = fn_q;
    rd_data[IRQ_EN_BIT]          = en_q;
    rd_data[FREQ_W-1:0]          = freq_q;
  end

  assign fn   = fn_q;
  assign freq = freq_q;
  assign irq  = evt_q;

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[IRQ_EN_BIT]) |=> !irq);
  assert_irq_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q));
  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && !wr_data[IRQ_EN_BIT])) |=> irq);
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int FREQ_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  output logic              div_q
);
  localparam int CNT_W = (MAX_CODE < 2) ? 1 : MAX_CODE;

  logic [FREQ_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              q_d;
  logic              code_ok;
  logic [CNT_W-1:0]  half_m1;

  assign code_ok = (freq >= FREQ_W'(1)) && (freq <= FREQ_W'(MAX_CODE));
  assign half_m1 = code_ok ? CNT_W'((1 << (freq - FREQ_W'(1))) - 1) : '0;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = div_q;
    if (freq != code_q || !code_ok) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_d = '0;
      q_d   = ~div_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else begin
      code_q <= freq;
      cnt_q  <= cnt_d;
      div_q  <= q_d;
    end
  end

  assert_undef_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (freq > FREQ_W'(MAX_CODE)) |=> !div_q);
  assert_restart_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (freq != code_q) |=> (!div_q && cnt_q == '0));
endmodule

// File: rtl/clkout_pinmux.sv
module clkout_pinmux (
  input  logic                clk,
  input  logic                rst_n,
  input  clkout_pkg::pin_fn_e fn,
  input  logic                ref_pass,
  input  logic                div_q,
  input  logic                pa_on,
  input  logic                ser_data,
  input  logic                ser_clk,
  input  logic                gpio_level,
  input  logic                three_wire_mode,
  input  logic                spi_miso_data,
  output logic                pin_out,
  output logic                miso_out
);
  import clkout_pkg::*;

  logic pa_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pa_n_q <= 1'b1;
    else        pa_n_q <= ~pa_on;
  end

  always_comb begin
    unique case (fn)
      FN_DIVCLK: pin_out = ref_pass ? clk : div_q;
      FN_PA_N:   pin_out = pa_n_q;
      FN_SERIAL: pin_out = ser_data;
      default:   pin_out = gpio_level;
    endcase
  end

  assign miso_out = (fn == FN_SERIAL && three_wire_mode) ? ser_clk : spi_miso_data;

  assert_pa_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_PA_N) |=> (fn != FN_PA_N) || (pin_out == !$past(pa_on)));
  assert_miso_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fn != FN_SERIAL) |-> (miso_out == spi_miso_data));
endmodule

// File: rtl/clkout_sel.sv
module clkout_sel #(
  parameter int DATA_W        = 8,
  parameter int FREQ_W        = 3,
  parameter int MAX_FREQ_CODE = 4,
  parameter int FREQ_RST      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pa_on,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              gpio_level,
  input  logic              three_wire_mode,
  input  logic              spi_miso_data,
  input  logic              wake,
  input  logic              crystal_stable,
  output logic              pin_out,
  output logic              miso_out,
  output logic              xtal_irq
);
  import clkout_pkg::*;

  logic              rst_m_q, rst_s_q;
  pin_fn_e           fn;
  logic [FREQ_W-1:0] freq;
  logic              div_q;
  logic              ref_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  clkout_ctrl_reg #(.DATA_W(DATA_W), .FREQ_W(FREQ_W), .FREQ_RST(FREQ_RST)) u_reg (
    .clk(clk), .rst_n(rst_s_q), .wr_en(wr_en), .wr_data(wr_data),
    .wake(wake), .crystal_stable(crystal_stable),
    .rd_data(rd_data), .fn(fn), .freq(freq), .irq(xtal_irq)
  );

  clkout_divider #(.FREQ_W(FREQ_W), .MAX_CODE(MAX_FREQ_CODE)) u_div (
    .clk(clk), .rst_n(rst_s_q), .freq(freq), .div_q(div_q)
  );

  assign ref_pass = (freq == '0);

  clkout_pinmux u_mux (
    .clk(clk), .rst_n(rst_s_q), .fn(fn), .ref_pass(ref_pass), .div_q(div_q),
    .pa_on(pa_on), .ser_data(ser_data), .ser_clk(ser_clk), .gpio_level(gpio_level),
    .three_wire_mode(three_wire_mode), .spi_miso_data(spi_miso_data),
    .pin_out(pin_out), .miso_out(miso_out)
  );

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_s_q)
    rd_data[4:3] == 2'b00);
endmodule

// File: tb/test_clkout_sel.sv
module test_clkout_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic pa_on, ser_data, ser_clk, gpio_level, three_wire_mode, spi_miso_data;
  logic wake, crystal_stable;
  logic pin_out, miso_out, xtal_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkout_sel i_clkout_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pa_on(pa_on), .ser_data(ser_data), .ser_clk(ser_clk), .gpio_level(gpio_level),
    .three_wire_mode(three_wire_mode), .spi_miso_data(spi_miso_data),
    .wake(wake), .crystal_stable(crystal_stable),
    .pin_out(pin_out), .miso_out(miso_out), .xtal_irq(xtal_irq)
  );

  // {fn, pa_on, ser_data, ser_clk, gpio, three_wire, spi_miso, exp_pin, exp_miso}
  localparam logic [9:0] VEC [10] = '{
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // measure run lengths at the pin for divided code k
  task automatic measure(input int k, input string req);
    int len = 0;
    bit seen = 1'b0;
    logic prev;
    int half = 1 << (k - 1);
    write_reg({2'b00, 3'b000, 3'(k)});
    repeat (3) @(negedge clk);
    prev = pin_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin_out != prev) begin
        if (seen) check(len == half, req, len, half);
        seen = 1'b1; len = 1; prev = pin_out;
      end else len++;
    end
    check(seen, req, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    pa_on = 0; ser_data = 0; ser_clk = 0; gpio_level = 0;
    three_wire_mode = 0; spi_miso_data = 0; wake = 0; crystal_stable = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset value
    check(rd_data == 8'h04, "R1", rd_data, 8'h04);
    check(xtal_irq == 1'b0, "R10 reset", xtal_irq, 0);
    write_reg(8'hFF);
    check(rd_data == 8'hE7, "R1 unused bits", rd_data, 8'hE7);

    // table walk: R6 R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      logic [9:0] v = VEC[i];
      write_reg({v[9:8], 6'b000100});
      @(negedge clk);
      pa_on = v[7]; ser_data = v[6]; ser_clk = v[5];
      gpio_level = v[4]; three_wire_mode = v[3]; spi_miso_data = v[2];
      repeat (2) @(negedge clk);
      check(pin_out == v[1], "R6/R7/R8 pin", pin_out, v[1]);
      check(miso_out == v[0], "R9 miso", miso_out, v[0]);
    end

    // R6 one-cycle registration
    write_reg(8'h44);
    pa_on = 1'b0;
    repeat (2) @(negedge clk);
    pa_on = 1'b1;
    #1 check(pin_out == 1'b1, "R6 before edge", pin_out, 1);
    @(negedge clk);
    check(pin_out == 1'b0, "R6 after edge", pin_out, 0);

    // R2 pass-through of reference
    write_reg(8'h00);
    @(posedge clk); #2;
    check(pin_out == 1'b1, "R2 high phase", pin_out, 1);
    @(negedge clk); #2;
    check(pin_out == 1'b0, "R2 low phase", pin_out, 0);

    // R3 divided rates
    for (int k = 1; k <= 4; k++) measure(k, "R3");

    // R4 undefined codes
    for (int k = 5; k <= 7; k++) begin
      int highs = 0;
      write_reg({5'b00000, 3'(k)});
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (pin_out) highs++;
      end
      check(highs == 0, "R4", highs, 0);
    end

    // R5 switch code mid-phase, first high phase must be full
    begin
      int hl = 0;
      int guard = 0;
      write_reg(8'h04);
      repeat (5) @(negedge clk);
      write_reg(8'h03);
      while (!pin_out && guard < 40) begin @(negedge clk); guard++; end
      while (pin_out && hl < 40) begin hl++; @(negedge clk); end
      check(hl == 4, "R5 first high phase", hl, 4);
    end

    // R11 enable clear: no event
    write_reg(8'h04);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0; crystal_stable = 1'b1;
    repeat (2) @(negedge clk);
    check(xtal_irq == 1'b0, "R11 enable clear", xtal_irq, 0);
    crystal_stable = 1'b0;

    // R11 no wake: no event
    write_reg(8'h24);
    repeat (2) @(negedge clk);
    crystal_stable = 1'b1;
    repeat (2) @(negedge clk);
    check(xtal_irq == 1'b0, "R11 no wake", xtal_irq, 0);
    crystal_stable = 1'b0;

    // R10 capture after wake
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0; crystal_stable = 1'b1;
    @(negedge clk);
    check(xtal_irq == 1'b1, "R10 capture", xtal_irq, 1);
    crystal_stable = 1'b0;
    repeat (3) @(negedge clk);
    check(xtal_irq == 1'b1, "R10 holds", xtal_irq, 1);

    // R12 clear by enable write to zero
    write_reg(8'h04);
    check(xtal_irq == 1'b0, "R12 clear", xtal_irq, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule